// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash interface. It decides when a program or erase operation has finished inside the flash. The host logic that writes the command sequence pulses `start_i` and gives the target address, the data word being programmed and the method to use. It also marks each command write it sends on `cmd_wr_i`. The poller waits until the whole command sequence has gone out. It then issues reads to the target address, one at a time, through a valid/ready request channel and a separate response strobe.

Two ways of detecting completion are available. In data-poll mode, the polling bit of each returned word is compared with the polling bit of the data being programmed; for an erase it is compared with 1. In toggle mode, each returned word is compared with the one before it, and two equal words in a row mean the operation has finished. In both modes the flash may set its error bit on a word that does not yet show completion. The poller then reads once more. If that read shows completion, the operation counts as successful. If it does not, the poller reports an error and raises a request for the host to send the flash reset command. A per-operation limit on the number of polls ends a stuck operation with a timeout error.

Top module: `flash_done_poller`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `rd_req_o`, `done_o`, `err_o`, `err_timeout_o` and `reset_req_o` are all 0.
- R2: After an accepted start, no read is requested until `PROG_WRITES` (default 4) strobes on `cmd_wr_i` for a program (`erase_i`=0), or `ERASE_WRITES` (default 6) strobes for an erase (`erase_i`=1). `rd_req_o` rises in the cycle after the clock edge that samples the last strobe.
- R3: At most one read is in flight. `rd_req_o` stays high with a stable `rd_addr_o` until `rd_ready_i` is sampled high, and it is low in the cycle after acceptance. Every read goes to the address latched at start.
- R4: In data-poll mode (`toggle_mode_i`=0), a response completes the operation when its bit `POLL_BIT` (default 7) equals bit `POLL_BIT` of `expect_i` for a program, or equals 1 for an erase. `done_o` then pulses for one cycle, in the cycle after that response, and `err_o` stays low.
- R5: In toggle mode (`toggle_mode_i`=1), a response completes the operation when the whole word equals the previous response of the same operation. The first response of an operation never completes it.
- R6: A response that does not complete the operation but has bit `ERR_BIT` (default 5) set causes exactly one further read. If that read completes the operation, `done_o` pulses and `reset_req_o` stays low.
- R7: If that confirming read does not complete the operation, `err_o` pulses with `err_timeout_o` low. `reset_req_o` is then set and held until `reset_ack_i` is sampled high.
- R8: While `reset_req_o` is high, `start_i` is ignored: `busy_o` stays low and no read is requested.
- R9: When the number of responses reaches `max_polls_i` (a value of 0 counts as 1) without completion and without the error bit, `err_o` and `err_timeout_o` pulse together and `reset_req_o` stays low.
- R10: A `start_i` pulse while `busy_o` is high is ignored; the running operation keeps its address and its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for one operation |
| erase_i | input | 1 | 1 = erase, 0 = program |
| toggle_mode_i | input | 1 | 1 = toggle mode, 0 = data-poll mode |
| addr_i | input | AW | Target address, latched at start |
| expect_i | input | DW | Data being programmed |
| max_polls_i | input | PCW | Poll limit, latched at start |
| cmd_wr_i | input | 1 | One strobe per command write sent to the flash |
| rd_req_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read address |
| rd_ready_i | input | 1 | Read request accepted |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | DW | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Failure pulse |
| err_timeout_o | output | 1 | Failure cause is the poll limit, valid with `err_o` |
| reset_req_o | output | 1 | Host must send the flash reset command |
| reset_ack_i | input | 1 | Reset command sent, clears `reset_req_o` |

## Verification
The bench builds the block with a 12-bit address and a 5-bit poll limit, and keeps the defaults for the data width, the write counts and the bit positions. With the 5-bit limit, limits from 0 to 20 are cheap to run. The zero case, a timeout on the very first read, is therefore reachable, and so are long toggle runs that end in completion, a confirmed error or a timeout. With the default 4 and 6 write counts, both lengths of the command sequence are exercised against random gaps between the strobes.

// File: rtl/fdp_pkg.sv
// Shared types for the flash completion poller.
// Assumes: nothing beyond IEEE 1800-2017.
package fdp_pkg;

    // Controller phases of one operation.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for start
        PH_ARM  = 2'd1,   // counting command writes
        PH_REQ  = 2'd2,   // read request presented
        PH_WAIT = 2'd3    // waiting for read data
    } fdp_phase_e;

endpackage

// File: rtl/fdp_cmd_counter.sv
// Counts the command-write strobes of one operation and flags the last one.
// Assumes: clear_i comes with the accepted start, and is_erase_i is valid then.
module fdp_cmd_counter #(
    parameter int unsigned PROG_WRITES  = 4,
    parameter int unsigned ERASE_WRITES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic is_erase_i,
    input  logic en_i,
    input  logic wr_i,
    output logic seq_done_o
);
    localparam int unsigned NMAX = (PROG_WRITES > ERASE_WRITES) ? PROG_WRITES : ERASE_WRITES;
    localparam int unsigned CW   = $clog2(NMAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need_q;

    // Latch the required count and count the strobes seen while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            need_q <= CW'(PROG_WRITES);
        end else if (clear_i) begin
            cnt_q  <= '0;
            need_q <= is_erase_i ? CW'(ERASE_WRITES) : CW'(PROG_WRITES);
        end else if (en_i && wr_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The last strobe of the sequence ends the arming phase.
    always_comb seq_done_o = en_i && wr_i && (cnt_q == need_q - 1'b1);

    AST_WR_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (cnt_q < need_q)); // R2

endmodule

// File: rtl/fdp_status_eval.sv
// Looks at one returned status word and decides completion and the error flag.
// Assumes: DW is larger than both bit positions.
module fdp_status_eval #(
    parameter int unsigned DW       = 16,
    parameter int unsigned POLL_BIT = 7,
    parameter int unsigned ERR_BIT  = 5
) (
    input  logic          toggle_i,
    input  logic          exp_bit_i,
    input  logic          have_prev_i,
    input  logic [DW-1:0] prev_i,
    input  logic [DW-1:0] cur_i,
    output logic          complete_o,
    output logic          err_flag_o
);
    logic poll_match;
    logic same_word;

    // Compare the status word in both ways; the mode picks which one is used.
    always_comb begin
        poll_match = (cur_i[POLL_BIT] == exp_bit_i);
        same_word  = have_prev_i && (cur_i == prev_i);
        complete_o = toggle_i ? same_word : poll_match;
        err_flag_o = cur_i[ERR_BIT];
    end

endmodule

// File: rtl/fdp_poll_limit.sv
// Counts plain retries and flags the read that reaches the poll limit.
// Assumes: a limit of 0 acts as 1; inc_i only comes for reads that are not last_o.
module fdp_poll_limit #(
    parameter int unsigned PCW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_i,
    input  logic [PCW-1:0] limit_i,
    input  logic           inc_i,
    output logic           last_o
);
    logic [PCW-1:0] lim_q;
    logic [PCW-1:0] cnt_q;
    logic [PCW:0]   next_cnt;

    // Latch the limit at start and count the retries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            lim_q <= limit_i;
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The current read is the last allowed one once the count reaches the limit.
    always_comb begin
        next_cnt = {1'b0, cnt_q} + 1'b1;
        last_o   = (lim_q == '0) || (next_cnt >= {1'b0, lim_q});
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q != '0) |-> (cnt_q < lim_q)); // R9

endmodule

// File: rtl/flash_done_poller.sv
// Host-side poller that decides when a flash program or erase has finished.
// Waits for the command sequence, then reads the target address one request at a time.
// Stops on completion, on a confirmed error bit, or at the poll limit.
// Assumes: the responder returns exactly one rd_rvalid_i per accepted request, at least
// one cycle after acceptance; rd_rvalid_i outside a pending read is ignored.
module flash_done_poller
    import fdp_pkg::*;
#(
    parameter int unsigned AW           = 18,
    parameter int unsigned DW           = 16,
    parameter int unsigned PCW          = 10,
    parameter int unsigned PROG_WRITES  = 4,
    parameter int unsigned ERASE_WRITES = 6,
    parameter int unsigned POLL_BIT     = 7,
    parameter int unsigned ERR_BIT      = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           erase_i,
    input  logic           toggle_mode_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  expect_i,
    input  logic [PCW-1:0] max_polls_i,
    input  logic           cmd_wr_i,
    output logic           rd_req_o,
    output logic [AW-1:0]  rd_addr_o,
    input  logic           rd_ready_i,
    input  logic           rd_rvalid_i,
    input  logic [DW-1:0]  rd_rdata_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           err_o,
    output logic           err_timeout_o,
    output logic           reset_req_o,
    input  logic           reset_ack_i
);
    fdp_phase_e     phase_q;
    logic [AW-1:0]  addr_q;
    logic           exp_bit_q;
    logic           toggle_q;
    logic           have_prev_q;
    logic [DW-1:0]  prev_q;
    logic           confirm_q;
    logic           done_q;
    logic           err_q;
    logic           tmo_q;
    logic           rstreq_q;

    logic           accept_start;
    logic           seq_done;
    logic           rsp_take;
    logic           complete;
    logic           err_flag;
    logic           poll_last;
    logic           retry_inc;

    // Decode the events that drive the controller.
    always_comb begin
        accept_start = (phase_q == PH_IDLE) && start_i && !rstreq_q;
        rsp_take     = (phase_q == PH_WAIT) && rd_rvalid_i;
        retry_inc    = rsp_take && !complete && !confirm_q && !err_flag && !poll_last;
    end

    fdp_cmd_counter #(
        .PROG_WRITES  (PROG_WRITES),
        .ERASE_WRITES (ERASE_WRITES)
    ) u_cmd_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (accept_start),
        .is_erase_i (erase_i),
        .en_i       (phase_q == PH_ARM),
        .wr_i       (cmd_wr_i),
        .seq_done_o (seq_done)
    );

    fdp_status_eval #(
        .DW       (DW),
        .POLL_BIT (POLL_BIT),
        .ERR_BIT  (ERR_BIT)
    ) u_eval (
        .toggle_i    (toggle_q),
        .exp_bit_i   (exp_bit_q),
        .have_prev_i (have_prev_q),
        .prev_i      (prev_q),
        .cur_i       (rd_rdata_i),
        .complete_o  (complete),
        .err_flag_o  (err_flag)
    );

    fdp_poll_limit #(
        .PCW (PCW)
    ) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept_start),
        .limit_i (max_polls_i),
        .inc_i   (retry_inc),
        .last_o  (poll_last)
    );

    // Main controller: arm, request, wait, and decide the outcome of each response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            addr_q      <= '0;
            exp_bit_q   <= 1'b0;
            toggle_q    <= 1'b0;
            have_prev_q <= 1'b0;
            prev_q      <= '0;
            confirm_q   <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            tmo_q       <= 1'b0;
            rstreq_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
            if (reset_ack_i) begin
                rstreq_q <= 1'b0;
            end
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept_start) begin
                        addr_q      <= addr_i;
                        exp_bit_q   <= erase_i ? 1'b1 : expect_i[POLL_BIT];
                        toggle_q    <= toggle_mode_i;
                        have_prev_q <= 1'b0;
                        confirm_q   <= 1'b0;
                        phase_q     <= PH_ARM;
                    end
                end
                PH_ARM: begin
                    if (seq_done) begin
                        phase_q <= PH_REQ;
                    end
                end
                PH_REQ: begin
                    if (rd_ready_i) begin
                        phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (rsp_take) begin
                        prev_q      <= rd_rdata_i;
                        have_prev_q <= 1'b1;
                        if (complete) begin
                            done_q  <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else if (confirm_q) begin
                            err_q    <= 1'b1;
                            rstreq_q <= 1'b1;
                            phase_q  <= PH_IDLE;
                        end else if (err_flag) begin
                            confirm_q <= 1'b1;
                            phase_q   <= PH_REQ;
                        end else if (poll_last) begin
                            err_q   <= 1'b1;
                            tmo_q   <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_REQ;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Drive the ports from the registered state.
    always_comb begin
        rd_req_o      = (phase_q == PH_REQ);
        rd_addr_o     = addr_q;
        busy_o        = (phase_q != PH_IDLE);
        done_o        = done_q;
        err_o         = err_q;
        err_timeout_o = tmo_q;
        reset_req_o   = rstreq_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o))); // R3
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ready_i) |=> !rd_req_o); // R3
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R4
    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_rvalid_i)); // R4
    AST_RSTREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req_o && !reset_ack_i) |=> reset_req_o); // R7
    AST_RSTREQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> (!busy_o && !rd_req_o)); // R8
    AST_TMO_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout_o |-> (err_o && !reset_req_o)); // R9

endmodule

// File: tb/test_flash_done_poller.sv
// Self-checking bench: a random-latency read responder plus scripted status words.
module test_flash_done_poller;
    localparam int unsigned AW  = 12;
    localparam int unsigned DW  = 16;
    localparam int unsigned PCW = 5;
    localparam int NRSP = 48;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           erase_i = 1'b0;
    logic           toggle_mode_i = 1'b0;
    logic [AW-1:0]  addr_i = '0;
    logic [DW-1:0]  expect_i = '0;
    logic [PCW-1:0] max_polls_i = '0;
    logic           cmd_wr_i = 1'b0;
    logic           rd_req_o;
    logic [AW-1:0]  rd_addr_o;
    logic           rd_ready_i;
    logic           rd_rvalid_i;
    logic [DW-1:0]  rd_rdata_i;
    logic           busy_o, done_o, err_o, err_timeout_o, reset_req_o;
    logic           reset_ack_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] rsp [NRSP];
    int rsp_idx = 0;
    logic [AW-1:0] tgt = '0;

    always #4 clk = ~clk;

    flash_done_poller #(.AW(AW), .DW(DW), .PCW(PCW)) i_flash_done_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
        .toggle_mode_i(toggle_mode_i), .addr_i(addr_i), .expect_i(expect_i),
        .max_polls_i(max_polls_i), .cmd_wr_i(cmd_wr_i), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i), .rd_rvalid_i(rd_rvalid_i),
        .rd_rdata_i(rd_rdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .err_timeout_o(err_timeout_o), .reset_req_o(reset_req_o), .reset_ack_i(reset_ack_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Outcome model: 0 done, 1 confirmed error, 2 timeout; reads = responses consumed.
    function automatic int predict(input bit tog, input bit erase, input logic [DW-1:0] expv,
                                   input int maxp, output int reads);
        bit conf = 0;
        bit eb = erase ? 1'b1 : expv[7];
        int lim = (maxp == 0) ? 1 : maxp;
        int retries = 0;
        for (int i = 0; i < NRSP; i++) begin
            bit comp = tog ? (i > 0 && rsp[i] == rsp[i-1]) : (rsp[i][7] == eb);
            reads = i + 1;
            if (comp) return 0;
            if (conf) return 1;
            if (rsp[i][5]) conf = 1;
            else if (retries + 1 >= lim) return 2;
            else retries++;
        end
        reads = NRSP;
        return 3;
    endfunction

    // Read responder: accepts after a random delay, returns the next scripted word.
    initial begin
        rd_ready_i = 1'b0;
        rd_rvalid_i = 1'b0;
        rd_rdata_i = '0;
        forever begin
            @(negedge clk);
            if (rd_req_o) begin
                int d;
                d = $urandom % 3;
                repeat (d) @(negedge clk);
                chk(rd_addr_o == tgt, "R3 address", int'(rd_addr_o), int'(tgt));
                rd_ready_i = 1'b1;
                @(negedge clk);
                rd_ready_i = 1'b0;
                chk(!rd_req_o, "R3 single outstanding", int'(rd_req_o), 0);
                d = $urandom % 3;
                repeat (d) @(negedge clk);
                rd_rvalid_i = 1'b1;
                rd_rdata_i = rsp[rsp_idx % NRSP];
                rsp_idx++;
                @(negedge clk);
                rd_rvalid_i = 1'b0;
            end
        end
    end

    task automatic run_op(input bit erase, input bit tog, input logic [DW-1:0] expv,
                          input int maxp, input bit stray);
        int kind, reads, need, waited;
        bit dn, er, tm;
        tgt = AW'($urandom);
        rsp_idx = 0;
        kind = predict(tog, erase, expv, maxp, reads);
        @(negedge clk);
        start_i = 1'b1; erase_i = erase; toggle_mode_i = tog;
        addr_i = tgt; expect_i = expv; max_polls_i = PCW'(maxp);
        @(negedge clk);
        start_i = 1'b0;
        need = erase ? 6 : 4;
        for (int k = 0; k < need; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            chk(!rd_req_o, "R2 no read before sequence end", int'(rd_req_o), 0);
            cmd_wr_i = 1'b1;
            @(negedge clk);
            cmd_wr_i = 1'b0;
        end
        chk(rd_req_o, "R2 read after last write", int'(rd_req_o), 1);
        if (stray) begin
            // R10: a second start during the operation must not retarget it.
            addr_i = ~tgt;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        dn = 0; er = 0; tm = 0; waited = 0;
        while (!dn && !er && waited < 3000) begin
            if (done_o) dn = 1;
            if (err_o) begin er = 1; tm = err_timeout_o; end
            if (!dn && !er) @(negedge clk);
            waited++;
        end
        chk(rsp_idx == reads, "R4/R5/R6 reads consumed", rsp_idx, reads);
        case (kind)
            0: chk(dn && !er, tog ? "R5 toggle completion" : "R4 poll completion", int'(dn), 1);
            1: chk(er && !tm, "R7 confirmed error", int'({er, tm}), 2);
            default: chk(er && tm, "R9 timeout", int'({er, tm}), 3);
        endcase
        @(negedge clk);
        chk(!done_o && !err_o, "R4 single-cycle pulse", int'({done_o, err_o}), 0);
        chk(reset_req_o == (kind == 1), "R7 reset request", int'(reset_req_o), int'(kind == 1));
        if (reset_req_o) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(!busy_o && !rd_req_o, "R8 start ignored", int'({busy_o, rd_req_o}), 0);
            chk(reset_req_o, "R7 request held", int'(reset_req_o), 1);
            reset_ack_i = 1'b1;
            @(negedge clk);
            reset_ack_i = 1'b0;
            chk(!reset_req_o, "R7 cleared by ack", int'(reset_req_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        chk(!busy_o && !rd_req_o && !done_o && !err_o && !err_timeout_o && !reset_req_o,
            "R1 reset state", int'({busy_o, rd_req_o, done_o, err_o, err_timeout_o, reset_req_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 directed: program, bit 7 matches on the third read.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h0000;
        rsp[2] = 16'h0080;
        run_op(1'b0, 1'b0, 16'h00FF, 10, 1'b0);
        // R4 directed: erase expects 1 whatever expect_i holds.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h0080;
        run_op(1'b1, 1'b0, 16'h0000, 10, 1'b0);
        // R5 directed: first two words equal complete on the second read.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h1234;
        run_op(1'b0, 1'b1, 16'h0000, 10, 1'b0);
        // R6 directed: error bit, then confirming read completes.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h0080;
        rsp[0] = 16'h0020;
        run_op(1'b0, 1'b0, 16'h0080, 10, 1'b0);
        // R7 directed: error bit, confirming read still pending.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h0020;
        run_op(1'b0, 1'b0, 16'h0080, 10, 1'b0);
        // R9 directed: limit 0 acts as 1.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h0000;
        run_op(1'b1, 1'b0, 16'h0000, 0, 1'b0);
        // R9 directed: limit 5 in toggle mode with alternating words.
        for (int i = 0; i < NRSP; i++) rsp[i] = (i % 2) ? 16'h0040 : 16'h0000;
        run_op(1'b0, 1'b1, 16'h0000, 5, 1'b0);
        // R10 directed: stray start during polling.
        for (int i = 0; i < NRSP; i++) rsp[i] = 16'h0000;
        rsp[3] = 16'h0080;
        run_op(1'b0, 1'b0, 16'h0080, 10, 1'b1);

        // Random operations.
        for (int n = 0; n < 60; n++) begin
            bit tog = $urandom % 2;
            bit er  = $urandom % 2;
            logic [DW-1:0] ev = DW'($urandom);
            for (int i = 0; i < NRSP; i++) begin
                logic [DW-1:0] w = DW'($urandom) & 16'hFFDF;
                if ($urandom % 7 == 0) w[5] = 1'b1;
                if (!tog) w[7] = ($urandom % 5 == 0) ? (er ? 1'b1 : ev[7]) : (er ? 1'b0 : ~ev[7]);
                if (tog && i > 0 && $urandom % 5 == 0) w = rsp[i-1];
                rsp[i] = w;
            end
            run_op(er, tog, ev, $urandom % 21, ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule